// File: doc/BRIEF.md
# SPI Interrupt Status and Enable Registers

This block holds the interrupt state of an SPI controller. The SPI core sends it one-cycle event strobes and a few level conditions. These are the slave-select activity, the master/slave configuration and the enable bit. Each event sets its own bit in a status word. Software reads that word and flips bits in it by writing ones. Writing a zero to a bit leaves it alone.

A second word holds one enable bit per status bit. A global enable bit sits at its own offset. The single interrupt output is raised when the global enable is set and at least one status bit is set together with its enable.

The block also exports a transfer-inhibit level for the master sequencer. Two fault sources are derived inside the block from the slave-select condition. The mode fault is edge-triggered. The slave mode fault is level-forced.

Top module: `spi_irq_regs`

## Requirements
- R1: After reset, the status word at offset 0x20, the enable word at 0x28 and the global enable at 0x1C all read as zero, and `irqOut` is low.
- R2: A write to offset 0x20 inverts every status bit whose data bit is 1 and leaves every status bit whose data bit is 0 unchanged.
- R3: When a hardware set and a toggle-write reach the same status bit in the same cycle, the bit ends at 1.
- R4: `undrStb` sets status bit 3 only while `isMaster` is 0 and `spiEnable` is 1. In any other configuration the strobe has no effect.
- R5: `txEmptyStb` sets status bit 2. `txInhibit` is 1 exactly while `isMaster` is 1 and status bit 2 is 1.
- R6: Status bit 0 (mode fault) is set at the clock edge where `ssActive` is first seen high after being low, provided `isMaster` is 1. Holding `ssActive` high does not set the bit again after software has toggled it clear.
- R7: While `ssActive` is 1, `isMaster` is 0 and `spiEnable` is 0, status bit 1 (slave mode fault) is forced to 1 on every cycle, so a toggle-write cannot clear it.
- R8: The strobes map to status bits as follows: `rxOvrStb` to bit 4, `rxFullStb` to bit 5, `rxNotEmptyStb` to bit 6, `txHalfStb` to bit 7 and `ssModeStb` to bit 8.
- R9: Offset 0x28 is a plain read/write enable word covering status bits 0 to 8.
- R10: `irqOut` equals the global enable (bit 31 at offset 0x1C) ANDed with the OR of all status bits that are ANDed with their enables.
- R11: Status and enable bits above bit 8, bits other than 31 at 0x1C, and all other offsets read as 0. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register byte offset for reads and writes |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data of the addressed register, combinational |
| ssActive | input | 1 | Slave-select is asserted |
| isMaster | input | 1 | Device configured as master |
| spiEnable | input | 1 | SPI enable bit |
| undrStb | input | 1 | Transmit underrun event |
| txEmptyStb | input | 1 | Transmit register/FIFO emptied by a finished element |
| rxOvrStb | input | 1 | Receive overrun event |
| rxFullStb | input | 1 | Receive register/FIFO full event |
| rxNotEmptyStb | input | 1 | Receive register/FIFO not-empty event |
| txHalfStb | input | 1 | Transmit FIFO half-empty event |
| ssModeStb | input | 1 | Slave-select mode event |
| irqOut | output | 1 | Combined interrupt request |
| txInhibit | output | 1 | Master must not start another transfer |

## Verification
Some properties are checked on every cycle. The slave mode fault stays forced while its condition holds. A hardware set wins over a toggle. An underrun strobe in master mode is ignored. The interrupt output never rises without an enabled, set source under the global enable. Undefined status bits always read zero.

Other behaviour can only be shown by the bench's scenarios. This covers the exact toggle arithmetic over multi-bit patterns and the one-shot nature of the mode-fault edge while slave-select is held. It also covers the reset values and the mapping of every strobe to its bit position. The bench compares these against its own cycle model.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  localparam int NUM_EVT   = 9;
  localparam int B_MODF    = 0;
  localparam int B_SMODF   = 1;
  localparam int B_TXEMPTY = 2;
  localparam int B_UNDR    = 3;
  localparam int B_RXOVR   = 4;
  localparam int B_RXFULL  = 5;
  localparam int B_RXNE    = 6;
  localparam int B_TXHALF  = 7;
  localparam int B_SSMODE  = 8;

  typedef struct packed {
    logic               wrStat;
    logic               wrEnab;
    logic               wrGie;
    logic               rdStat;
    logic               rdEnab;
    logic               rdGie;
    logic [NUM_EVT-1:0] hwSet;
  } irqCtl_t;

endpackage

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_STAT = 8'h20,
  parameter logic [ADDR_W-1:0] OFS_ENAB = 8'h28,
  parameter logic [ADDR_W-1:0] OFS_GIE  = 8'h1C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              ssActive,
  input  logic              isMaster,
  input  logic              spiEnable,
  input  logic              undrStb,
  input  logic              txEmptyStb,
  input  logic              rxOvrStb,
  input  logic              rxFullStb,
  input  logic              rxNotEmptyStb,
  input  logic              txHalfStb,
  input  logic              ssModeStb,
  output irqCtl_t           ctl
);

  logic ssPrev;
  logic ssRise;
  logic selStat, selEnab, selGie;

  // Remember last slave-select level so the mode fault fires once per assertion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ssPrev <= 1'b0;
    else       ssPrev <= ssActive;
  end

  assign ssRise  = ssActive & ~ssPrev;
  assign selStat = (busAddr == OFS_STAT);
  assign selEnab = (busAddr == OFS_ENAB);
  assign selGie  = (busAddr == OFS_GIE);

  always_comb begin
    ctl = '0;
    ctl.wrStat = busWrEn & selStat;
    ctl.wrEnab = busWrEn & selEnab;
    ctl.wrGie  = busWrEn & selGie;
    ctl.rdStat = selStat;
    ctl.rdEnab = selEnab;
    ctl.rdGie  = selGie;
    ctl.hwSet[B_MODF]    = ssRise & isMaster;
    ctl.hwSet[B_SMODF]   = ssActive & ~isMaster & ~spiEnable;
    ctl.hwSet[B_TXEMPTY] = txEmptyStb;
    ctl.hwSet[B_UNDR]    = undrStb & ~isMaster & spiEnable;
    ctl.hwSet[B_RXOVR]   = rxOvrStb;
    ctl.hwSet[B_RXFULL]  = rxFullStb;
    ctl.hwSet[B_RXNE]    = rxNotEmptyStb;
    ctl.hwSet[B_TXHALF]  = txHalfStb;
    ctl.hwSet[B_SSMODE]  = ssModeStb;
  end

endmodule

// File: rtl/spi_irq_data.sv
module spi_irq_data
  import spi_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GIE_BIT = 31
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqCtl_t            ctl,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  output logic [NUM_EVT-1:0] statQ,
  output logic [NUM_EVT-1:0] enQ,
  output logic               gieQ,
  output logic               irqOut
);

  localparam int PAD_W = DATA_W - NUM_EVT;

  logic [NUM_EVT-1:0] wrBits;
  logic               unusedWrBits;

  assign wrBits       = busWrData[NUM_EVT-1:0];
  assign unusedWrBits = ^busWrData[DATA_W-1:NUM_EVT];

  // Per-bit status: toggle on write of one, hardware set has the last word
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_stat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statQ[i] <= 1'b0;
      else       statQ[i] <= (statQ[i] ^ (ctl.wrStat & wrBits[i])) | ctl.hwSet[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          enQ <= '0;
    else if (ctl.wrEnab) enQ <= wrBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         gieQ <= 1'b0;
    else if (ctl.wrGie) gieQ <= busWrData[GIE_BIT];
  end

  assign irqOut = gieQ & (|(statQ & enQ));

  always_comb begin
    busRdData = '0;
    if (ctl.rdStat)     busRdData = {{PAD_W{1'b0}}, statQ};
    else if (ctl.rdEnab) busRdData = {{PAD_W{1'b0}}, enQ};
    else if (ctl.rdGie)  busRdData[GIE_BIT] = gieQ;
  end

endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int GIE_BIT = 31,
  parameter logic [ADDR_W-1:0] OFS_STAT = 8'h20,
  parameter logic [ADDR_W-1:0] OFS_ENAB = 8'h28,
  parameter logic [ADDR_W-1:0] OFS_GIE  = 8'h1C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              ssActive,
  input  logic              isMaster,
  input  logic              spiEnable,
  input  logic              undrStb,
  input  logic              txEmptyStb,
  input  logic              rxOvrStb,
  input  logic              rxFullStb,
  input  logic              rxNotEmptyStb,
  input  logic              txHalfStb,
  input  logic              ssModeStb,
  output logic              irqOut,
  output logic              txInhibit
);

  irqCtl_t            ctl;
  logic [NUM_EVT-1:0] statQ;
  logic [NUM_EVT-1:0] enQ;
  logic               gieQ;

  spi_irq_ctrl #(
    .ADDR_W(ADDR_W), .OFS_STAT(OFS_STAT), .OFS_ENAB(OFS_ENAB), .OFS_GIE(OFS_GIE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .ssActive(ssActive), .isMaster(isMaster), .spiEnable(spiEnable),
    .undrStb(undrStb), .txEmptyStb(txEmptyStb), .rxOvrStb(rxOvrStb),
    .rxFullStb(rxFullStb), .rxNotEmptyStb(rxNotEmptyStb), .txHalfStb(txHalfStb),
    .ssModeStb(ssModeStb), .ctl(ctl)
  );

  spi_irq_data #(
    .DATA_W(DATA_W), .GIE_BIT(GIE_BIT)
  ) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busWrData(busWrData),
    .busRdData(busRdData), .statQ(statQ), .enQ(enQ), .gieQ(gieQ), .irqOut(irqOut)
  );

  assign txInhibit = isMaster & statQ[B_TXEMPTY];

endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFS_STAT = 8'h20
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWrEn,
  input logic [DATA_W-1:0]  busWrData,
  input logic [DATA_W-1:0]  busRdData,
  input logic               ssActive,
  input logic               isMaster,
  input logic               spiEnable,
  input logic               undrStb,
  input logic               txEmptyStb,
  input logic               rxFullStb,
  input logic               irqOut,
  input logic [NUM_EVT-1:0] statQ,
  input logic [NUM_EVT-1:0] enQ,
  input logic               gieQ
);

  AST_SLAVE_MODF_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (ssActive && !isMaster && !spiEnable) |=> statQ[B_SMODF]); // R7

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    rxFullStb |=> statQ[B_RXFULL]); // R3

  AST_TXEMPTY_SETS: assert property (@(posedge clk) disable iff (!rstN)
    txEmptyStb |=> statQ[B_TXEMPTY]); // R5

  AST_UNDR_MASTER_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && undrStb && !statQ[B_UNDR] &&
     !(busWrEn && busAddr == OFS_STAT && busWrData[B_UNDR])) |=> !statQ[B_UNDR]); // R4

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (gieQ && ((statQ & enQ) != '0))); // R10

  AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == OFS_STAT) |-> (busRdData[DATA_W-1:NUM_EVT] == '0)); // R11

endmodule

bind spi_irq_regs spi_irq_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdData(busRdData), .ssActive(ssActive),
  .isMaster(isMaster), .spiEnable(spiEnable), .undrStb(undrStb),
  .txEmptyStb(txEmptyStb), .rxFullStb(rxFullStb), .irqOut(irqOut),
  .statQ(statQ), .enQ(enQ), .gieQ(gieQ)
);

// File: tb/spi_irq_regs_test.sv
module spi_irq_regs_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = 8'h20;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic ssActive = 0, isMaster = 0, spiEnable = 0;
  logic undrStb = 0, txEmptyStb = 0, rxOvrStb = 0, rxFullStb = 0;
  logic rxNotEmptyStb = 0, txHalfStb = 0, ssModeStb = 0;
  logic irqOut, txInhibit;

  int total = 0;
  int bad = 0;

  // behavioural reference state
  bit [8:0] mStat, mEn;
  bit       mGie, mSsPrev;

  always #5 clk = ~clk;

  spi_irq_regs uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .ssActive(ssActive),
    .isMaster(isMaster), .spiEnable(spiEnable), .undrStb(undrStb),
    .txEmptyStb(txEmptyStb), .rxOvrStb(rxOvrStb), .rxFullStb(rxFullStb),
    .rxNotEmptyStb(rxNotEmptyStb), .txHalfStb(txHalfStb), .ssModeStb(ssModeStb),
    .irqOut(irqOut), .txInhibit(txInhibit)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(logic [7:0] a);
    case (a)
      8'h20:   return {23'd0, mStat};
      8'h28:   return {23'd0, mEn};
      8'h1C:   return {mGie, 31'd0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string readTag(logic [7:0] a);
    case (a)
      8'h20:   return "R2";
      8'h28:   return "R9";
      8'h1C:   return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic compareAll();
    check(readTag(busAddr), busRdData, modelRead(busAddr));
    check("R10", {31'd0, irqOut}, {31'd0, mGie && ((mStat & mEn) != 0)});
    check("R5", {31'd0, txInhibit}, {31'd0, isMaster && mStat[2]});
  endtask

  // one clock: update the model with the inputs seen at the edge, then compare
  task automatic cyc();
    bit [8:0] setv;
    @(posedge clk);
    if (!rstN) begin
      mStat = 0; mEn = 0; mGie = 0; mSsPrev = 0;
    end else begin
      setv = 0;
      if (ssActive && !mSsPrev && isMaster)   setv[0] = 1;
      if (ssActive && !isMaster && !spiEnable) setv[1] = 1;
      if (txEmptyStb)                          setv[2] = 1;
      if (undrStb && !isMaster && spiEnable)   setv[3] = 1;
      if (rxOvrStb)      setv[4] = 1;
      if (rxFullStb)     setv[5] = 1;
      if (rxNotEmptyStb) setv[6] = 1;
      if (txHalfStb)     setv[7] = 1;
      if (ssModeStb)     setv[8] = 1;
      if (busWrEn && busAddr == 8'h20) mStat = mStat ^ busWrData[8:0];
      if (busWrEn && busAddr == 8'h28) mEn = busWrData[8:0];
      if (busWrEn && busAddr == 8'h1C) mGie = busWrData[31];
      mStat = mStat | setv;
      mSsPrev = ssActive;
    end
    #1;
    compareAll();
    undrStb = 0; txEmptyStb = 0; rxOvrStb = 0; rxFullStb = 0;
    rxNotEmptyStb = 0; txHalfStb = 0; ssModeStb = 0; busWrEn = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    busAddr = a; busWrEn = 1; busWrData = d;
    cyc();
  endtask

  task automatic rdChk(string tag, logic [7:0] a, logic [31:0] exp);
    busAddr = a;
    #1;
    check(tag, busRdData, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rstN = 1;
    cyc();
    // R1 reset state
    rdChk("R1", 8'h20, 0); rdChk("R1", 8'h28, 0); rdChk("R1", 8'h1C, 0);
    check("R1", {31'd0, irqOut}, 0);

    // R9 / R11 enable word, upper bits dropped
    wr(8'h28, 32'hFFFF_FFFF);
    rdChk("R9", 8'h28, 32'h1FF);

    // R2 toggle arithmetic
    wr(8'h20, 32'h0A5); rdChk("R2", 8'h20, 32'h0A5);
    wr(8'h20, 32'h005); rdChk("R2", 8'h20, 32'h0A0);
    wr(8'h20, 32'hFFFF_FE00); rdChk("R11", 8'h20, 32'h0A0);
    wr(8'h44, 32'hFFFF_FFFF); rdChk("R11", 8'h44, 0); rdChk("R11", 8'h20, 32'h0A0);

    // R10 global enable
    check("R10", {31'd0, irqOut}, 0);
    wr(8'h1C, 32'h8000_0000);
    rdChk("R10", 8'h1C, 32'h8000_0000);
    check("R10", {31'd0, irqOut}, 1);
    wr(8'h20, 32'h0A0);
    check("R10", {31'd0, irqOut}, 0);
    wr(8'h28, 32'h0);

    // R3 hardware set beats toggle
    rxFullStb = 1; wr(8'h20, 32'h020); rdChk("R3", 8'h20, 32'h020);
    wr(8'h20, 32'h020); rdChk("R3", 8'h20, 0);

    // R4 underrun gating
    isMaster = 1; undrStb = 1; cyc(); rdChk("R4", 8'h20, 0);
    isMaster = 0; spiEnable = 0; undrStb = 1; cyc(); rdChk("R4", 8'h20, 0);
    spiEnable = 1; undrStb = 1; cyc(); rdChk("R4", 8'h20, 32'h008);
    wr(8'h20, 32'h008);

    // R5 transmit empty and inhibit
    isMaster = 1; txEmptyStb = 1; cyc();
    rdChk("R5", 8'h20, 32'h004); check("R5", {31'd0, txInhibit}, 1);
    wr(8'h20, 32'h004); check("R5", {31'd0, txInhibit}, 0);

    // R6 mode fault once per slave-select assertion
    ssActive = 1; cyc(); rdChk("R6", 8'h20, 32'h001);
    wr(8'h20, 32'h001); cyc(); cyc(); rdChk("R6", 8'h20, 0);
    ssActive = 0; cyc(); ssActive = 1; cyc(); rdChk("R6", 8'h20, 32'h001);
    wr(8'h20, 32'h001); ssActive = 0; cyc();

    // R7 slave mode fault is forced while the condition holds
    isMaster = 0; spiEnable = 0; ssActive = 1; cyc(); rdChk("R7", 8'h20, 32'h002);
    wr(8'h20, 32'h002); rdChk("R7", 8'h20, 32'h002);
    ssActive = 0; cyc(); wr(8'h20, 32'h002); rdChk("R7", 8'h20, 0);

    // R8 remaining strobe positions
    rxOvrStb = 1; cyc(); rdChk("R8", 8'h20, 32'h010);
    rxNotEmptyStb = 1; cyc(); rdChk("R8", 8'h20, 32'h050);
    txHalfStb = 1; cyc(); rdChk("R8", 8'h20, 32'h0D0);
    ssModeStb = 1; cyc(); rdChk("R8", 8'h20, 32'h1D0);
    wr(8'h28, 32'h100); check("R10", {31'd0, irqOut}, 1);
    cyc();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule